// File: doc/BRIEF.md
# Temporally Offset Dual-Core Lockstep Checker

This block wraps two copies of a small synchronous accumulator core and runs them as a redundant pair. The primary copy takes the external input stream directly. The redundant copy takes the same stream after a fixed delay of `D` cycles. The primary's result is delayed by the same `D` cycles before a comparator checks it against the redundant copy's result on every cycle. Because the two copies handle the same work at different instants, a disturbance that strikes both copies at once corrupts different steps of the computation and still shows up as a difference.

Any difference produces a one-cycle `mismatch` indication and sets a `fault` flag that stays high until the next reset. The comparison is held off for the first `D` cycles after reset, while the delay stages still hold reset data. When `split_mode` is high during reset, the pair comes up as two independent cores, each with its own input stream and output, and the comparator stays off. The mode is taken only while reset is asserted. Two fault-injection masks, one per core, XOR a pattern into that core's state register so that the detection path can be tested.

Each core holds a `W`-bit accumulator that resets to zero. On each clock edge it adds the input data when the valid bit is high. The result is then XORed with that core's injection mask.

Top module: `lockstep_pair`

## Requirements
- R1: While `rst_n` is sampled low and on the cycle after it is released, `a_out`, `b_out`, `fault` and `mismatch` are all 0.
- R2: On each edge where `a_valid` is 1, `a_out` becomes the previous `a_out` plus `a_data`, modulo 2^W. When `a_valid` is 0 it holds. The result appears on the cycle after the edge. The sum is XORed with `inj_a` in both cases.
- R3: In lockstep mode, `b_out` is held at 0, and `b_valid`/`b_data` have no effect on any output.
- R4: In lockstep mode with both injection masks at zero, `fault` and `mismatch` stay 0 for any input stream.
- R5: A non-zero `inj_a` applied at clock edge k raises `mismatch` and `fault` after edge k+D+1. Both stay 0 after edges k through k+D.
- R6: A non-zero `inj_b` applied at clock edge k raises `mismatch` and `fault` after edge k+1. Both stay 0 after edge k.
- R7: `fault` stays 1 until reset once it is set. `mismatch` is 1 only for cycles whose comparison differed, so a corruption that is undone one edge later gives a one-cycle pulse.
- R8: No comparison result reaches `mismatch` or `fault` from the first D edges after reset release. A divergence that exists only during those cycles is never flagged.
- R9: With `split_mode` = 1 during reset, `b_out` accumulates `b_data` by the same rule as R2, using `b_valid` and `inj_b`. `a_out` follows R2. `fault` and `mismatch` stay 0 whatever the two streams are.
- R10: Changes on `split_mode` while `rst_n` is high have no effect. The mode taken at the last reset edge persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| split_mode | input | 1 | 1 = independent cores, 0 = lockstep; sampled only in reset |
| a_valid | input | 1 | Primary core input valid |
| a_data | input | W | Primary core input data |
| b_valid | input | 1 | Second core input valid (split mode only) |
| b_data | input | W | Second core input data (split mode only) |
| inj_a | input | W | XOR mask into primary core state (fault injection) |
| inj_b | input | W | XOR mask into second core state (fault injection) |
| a_out | output | W | Primary core accumulator |
| b_out | output | W | Second core accumulator in split mode, else 0 |
| fault | output | 1 | Sticky divergence flag, cleared by reset |
| mismatch | output | 1 | Per-cycle divergence indication |

## Verification
A corrupted accumulator in the primary core shows on `a_out` at once. On `fault` it shows only D+1 cycles later, because it must pass through the output delay stages first. Corruption in the redundant core is visible only on `fault`/`mismatch`, one cycle after it occurs. The bench uses these two latencies to tell a working delay alignment from one that is off by a stage. An error in the input or output delay stages, or in the arming counter, shows as spurious `mismatch` during clean random traffic. It can also show as a flag that arrives at the wrong cycle. A mode register that follows the live pin shows at once as a non-zero `b_out`.

// File: rtl/lane_core.sv
module lane_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic [W-1:0] flip,
  output logic [W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= (in_valid ? acc + in_data : acc) ^ flip;
  end
endmodule

// File: rtl/lockstep_pair.sv
module lockstep_pair #(
  parameter int W = 16,
  parameter int D = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         split_mode,
  input  logic         a_valid,
  input  logic [W-1:0] a_data,
  input  logic         b_valid,
  input  logic [W-1:0] b_data,
  input  logic [W-1:0] inj_a,
  input  logic [W-1:0] inj_b,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         fault,
  output logic         mismatch
);
  localparam int CW = $clog2(D + 1);

  logic          mode_q;
  logic [CW-1:0] arm_cnt;
  logic [W:0]    in_pipe  [D];
  logic [W-1:0]  out_pipe [D];
  logic [W-1:0]  acc_p, acc_r, r_data;
  logic          r_valid, cmp, fault_q, mis_q;

  always_ff @(posedge clk)
    if (!rst_n) mode_q <= split_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) begin
        in_pipe[i]  <= '0;
        out_pipe[i] <= '0;
      end
    end else begin
      in_pipe[0]  <= {a_valid, a_data};
      out_pipe[0] <= acc_p;
      for (int i = 1; i < D; i++) begin
        in_pipe[i]  <= in_pipe[i-1];
        out_pipe[i] <= out_pipe[i-1];
      end
    end
  end

  assign r_valid = mode_q ? b_valid : in_pipe[D-1][W];
  assign r_data  = mode_q ? b_data  : in_pipe[D-1][W-1:0];

  lane_core #(.W(W)) u_main (
    .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_data(a_data),
    .flip(inj_a), .acc(acc_p)
  );

  lane_core #(.W(W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .in_valid(r_valid), .in_data(r_data),
    .flip(inj_b), .acc(acc_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 arm_cnt <= '0;
    else if (arm_cnt != CW'(D)) arm_cnt <= arm_cnt + CW'(1);
  end

  assign cmp = !mode_q && (arm_cnt == CW'(D)) && (out_pipe[D-1] != acc_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      fault_q <= fault_q | cmp;
      mis_q   <= cmp;
    end
  end

  assign a_out    = acc_p;
  assign b_out    = mode_q ? acc_r : '0;
  assign fault    = fault_q;
  assign mismatch = mis_q;
endmodule

module lockstep_pair_chk #(
  parameter int W = 16,
  parameter int D = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       mode_q,
  input logic [$clog2(D+1)-1:0]     arm_cnt,
  input logic [W-1:0]               b_out,
  input logic                       fault,
  input logic                       mismatch
);
  localparam int CW = $clog2(D + 1);

  // R1
  fault_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!fault && !mismatch));

  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  // R7
  mismatch_sets_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> fault);

  // R8
  masked_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_cnt != CW'(D)) |=> !mismatch);

  // R9
  split_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !fault);

  // R3
  lock_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (b_out == '0));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

bind lockstep_pair lockstep_pair_chk #(.W(W), .D(D)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .arm_cnt(arm_cnt),
  .b_out(b_out), .fault(fault), .mismatch(mismatch)
);

// File: tb/sim_lockstep_pair.sv
module sim_lockstep_pair;
  localparam int W = 16;
  localparam int D = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic split_mode = 1'b0;
  logic a_valid = 1'b0, b_valid = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0, inj_a = '0, inj_b = '0;
  logic [W-1:0] a_out, b_out;
  logic fault, mismatch;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  lockstep_pair #(.W(W), .D(D)) u0 (
    .clk(clk), .rst_n(rst_n), .split_mode(split_mode),
    .a_valid(a_valid), .a_data(a_data), .b_valid(b_valid), .b_data(b_data),
    .inj_a(inj_a), .inj_b(inj_b), .a_out(a_out), .b_out(b_out),
    .fault(fault), .mismatch(mismatch)
  );

  // Behavioural reference model
  logic         m_mode, m_fault, m_mis, t_cmp;
  logic [W-1:0] m_a, m_b, t_old;
  logic [W:0]   t_in;
  logic [W:0]   m_iq [$];
  logic [W-1:0] m_oq [$];
  int           m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = split_mode; m_a = '0; m_b = '0; m_cnt = 0;
      m_fault = 1'b0; m_mis = 1'b0;
      m_iq = {}; m_oq = {};
      repeat (D) begin m_iq.push_back('0); m_oq.push_back('0); end
    end else begin
      t_old = m_oq.pop_front();
      t_cmp = !m_mode && (m_cnt == D) && (t_old != m_b);
      t_in  = m_iq.pop_front();
      m_iq.push_back({a_valid, a_data});
      m_oq.push_back(m_a);
      if (m_mode) t_in = {b_valid, b_data};
      m_a = (a_valid ? m_a + a_data : m_a) ^ inj_a;
      m_b = (t_in[W] ? m_b + t_in[W-1:0] : m_b) ^ inj_b;
      m_mis = t_cmp;
      m_fault = m_fault | t_cmp;
      if (m_cnt < D) m_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(a_out == m_a, "R2 a_out model", a_out, m_a);
      chk(b_out == (m_mode ? m_b : '0), m_mode ? "R9 b_out model" : "R3 b_out model",
          b_out, m_mode ? m_b : '0);
      chk(fault == m_fault, "R4 fault model", W'(fault), W'(m_fault));
      chk(mismatch == m_mis, "R7 mismatch model", W'(mismatch), W'(m_mis));
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic m);
    rst_n = 1'b0; split_mode = m; inj_a = '0; inj_b = '0;
    a_valid = 1'b0; b_valid = 1'b0;
    repeat (2) cyc();
    rst_n = 1'b1;
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      a_valid = 1'($urandom); a_data = W'($urandom);
      b_valid = 1'($urandom); b_data = W'($urandom);
      split_mode = 1'($urandom);
      cyc();
    end
    a_valid = 1'b0; b_valid = 1'b0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cmp_on = 1'b1;
    // R1 reset state
    chk(a_out == '0 && b_out == '0, "R1 outputs zero", a_out | b_out, '0);
    chk(!fault && !mismatch, "R1 flags zero", W'({fault, mismatch}), '0);

    // R8: divergence only inside the masked window
    inj_b = W'(1);
    cyc();
    cyc();
    inj_b = '0;
    repeat (3) cyc();
    chk(!fault, "R8 masked window not flagged", W'(fault), '0);

    // R2 accumulate, R3/R10 b side ignored in lockstep
    b_valid = 1'b1; b_data = W'(99); split_mode = 1'b1;
    a_valid = 1'b1; a_data = W'(5);   cyc();
    a_data = W'(7);   cyc();
    a_data = W'(100); cyc();
    a_valid = 1'b0;
    chk(a_out == W'(112), "R2 sum of 5+7+100", a_out, W'(112));
    chk(b_out == '0, "R10 pin change after reset ignored", b_out, '0);
    cyc();
    chk(a_out == W'(112), "R2 hold when invalid", a_out, W'(112));
    chk(b_out == '0, "R3 b inputs ignored", b_out, '0);
    b_valid = 1'b0;

    rand_run(300);
    chk(!fault && !mismatch, "R4 clean lockstep run", W'({fault, mismatch}), '0);

    // R5 primary injection latency D+1
    a_valid = 1'b1; a_data = W'(3);
    inj_a = W'(16'h0010);
    cyc();
    inj_a = '0;
    chk(!fault, "R5 no flag after edge k", W'(fault), '0);
    for (int i = 1; i <= D; i++) begin
      cyc();
      chk(!fault && !mismatch, "R5 no flag before k+D+1", W'({fault, mismatch}), '0);
    end
    cyc();
    chk(fault && mismatch, "R5 flag after edge k+D+1", W'({fault, mismatch}), W'(3));
    a_valid = 1'b0;

    // R6 / R7 redundant injection, transient
    do_reset(1'b0);
    chk(!fault, "R7 reset clears fault", W'(fault), '0);
    repeat (D + 2) cyc();
    inj_b = W'(16'h0008);
    cyc();
    chk(!fault, "R6 no flag after edge k", W'(fault), '0);
    cyc();
    inj_b = '0;
    chk(fault && mismatch, "R6 flag after edge k+1", W'({fault, mismatch}), W'(3));
    cyc();
    chk(!mismatch, "R7 mismatch one cycle only", W'(mismatch), '0);
    chk(fault, "R7 fault sticky", W'(fault), W'(1));
    rand_run(20);
    chk(fault, "R7 fault still sticky", W'(fault), W'(1));

    // R9 split mode
    do_reset(1'b1);
    split_mode = 1'b0;
    a_valid = 1'b1; a_data = W'(10);
    b_valid = 1'b1; b_data = W'(3);
    cyc();
    a_valid = 1'b0;
    b_data = W'(4);
    cyc();
    b_valid = 1'b0;
    chk(a_out == W'(10), "R9 a side independent", a_out, W'(10));
    chk(b_out == W'(7), "R9 b side accumulates", b_out, W'(7));
    inj_a = W'(16'h0100);
    cyc();
    inj_a = '0;
    repeat (D + 2) cyc();
    chk(!fault && !mismatch, "R9 comparator off in split", W'({fault, mismatch}), '0);
    rand_run(200);
    chk(b_out == m_b, "R10 split persists despite pin", b_out, m_b);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule